// File: doc/BRIEF.md
# Line Brownout Monitor with Current-Limit Reference

This block watches the rectified mains through a stream of digitized samples. It keeps the largest sample seen in each sampling cycle and acts on that peak only when the cycle ends. Two results come from the peak. The first is a run/stop decision for the PWM stage, with separate start and stop thresholds and a debounced stop. The second is a current-limit code for the cycle-by-cycle comparator. That code falls in a straight line as the line voltage rises, so the converter's output power limit stays roughly flat across the input range.

All timing is counted in ticks of a 1 µs enable pulse (`tick_i`). The cycle length and the stop debounce both stretch when the light-load flag is set. A supply-band input holds the PWM off while the supply is too marginal for a clean restart. A half-limit input halves the limit code to cut loss in the sense resistor at heavy load.

Top module: `line_brownout_mon`

## Requirements
- R1: A sampling cycle lasts CYC_NORM ticks, or CYC_LIGHT ticks while `light_load_i` is high. The first cycle starts at reset release. The stored peak is replaced on the last tick of each cycle (the update), and decisions based on it appear at the outputs one clock after the update edge.
- R2: The stored peak is the largest accepted sample code of the cycle just ended. The running maximum restarts from zero after every update.
- R3: Samples presented during the last HOLD ticks of a cycle are ignored.
- R4: While stopped, an update whose peak is at least ON_CODE (default 228) sets `pwm_en_o` to 1, provided `vdd_band_i` is low.
- R5: While `vdd_band_i` is high, an update cannot restart the PWM, whatever the peak.
- R6: While running, in normal load, an update whose peak is below OFF_CODE (default 204) starts a stop debounce. If every later update is also below OFF_CODE, `pwm_en_o` falls exactly DEB_NORM ticks after the clock edge that follows that update.
- R7: In light load the stop debounce lasts DEB_LIGHT ticks instead of DEB_NORM ticks.
- R8: An update whose peak is at or above OFF_CODE during the debounce cancels it. A later low peak restarts the full debounce.
- R9: A peak in [OFF_CODE, ON_CODE) changes nothing: a stopped block stays stopped and a running block keeps running.
- R10: At each update the limit code becomes L_LO (230) if the peak is at or below LINE_LO (244). It becomes L_HI (195) if the peak is at or above LINE_HI (732). Otherwise it is L_LO − floor((peak − LINE_LO)·(L_LO − L_HI)/(LINE_HI − LINE_LO)). The code is held between updates.
- R11: While `half_lim_i` is high, `limit_o` equals the held limit code shifted right by one bit, with no clock delay.
- R12: During reset `pwm_en_o` is 0 and `limit_o` is L_HI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 1 µs timebase enable |
| smp_vld_i | input | 1 | Line sample valid strobe |
| smp_code_i | input | CODE_W | Line sample code (default scale 0.5 V DC per LSB) |
| light_load_i | input | 1 | Light-load flag: longer cycle and debounce |
| half_lim_i | input | 1 | Halve the limit code |
| vdd_band_i | input | 1 | Supply in the marginal band: block restart |
| pwm_en_o | output | 1 | PWM enable |
| limit_o | output | LIM_W | Current-limit reference code (2 mV per LSB) |

## Verification
The bound checker watches every cycle for four things. The PWM may only start on an update with a high enough peak and a clear supply band. It may never stop on an update whose peak is acceptable. The stored peak may change only at an update. The limit code may move only after an update or a half-limit change, and it always stays inside its endpoints. The exact debounce length in both load modes, the cancellation of a pending stop, the tail window that discards samples, and the interpolated limit value for every input code cannot be expressed as per-cycle properties. The bench shows these with a short-timing configuration and a full sweep of the sample code.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [1:0] {
    BO_OFF  = 2'd0,
    BO_RUN  = 2'd1,
    BO_PEND = 2'd2
  } bo_state_e;
endpackage

// File: rtl/lbm_cycle_timer.sv
module lbm_cycle_timer #(
  parameter int CYC_NORM  = 220,
  parameter int CYC_LIGHT = 650,
  parameter int HOLD      = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic light_i,
  output logic upd_o,
  output logic hold_o
);
  localparam int CMAX = (CYC_LIGHT > CYC_NORM) ? CYC_LIGHT : CYC_NORM;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] cnt_q, len;

  assign len    = light_i ? CW'(CYC_LIGHT) : CW'(CYC_NORM);
  // >= so a shortened cycle closes at once after a mode switch
  assign upd_o  = tick_i && (cnt_q >= len - CW'(1));
  assign hold_o = cnt_q >= len - CW'(HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (upd_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/lbm_peak_hold.sv
module lbm_peak_hold #(
  parameter int CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [CODE_W-1:0] smp_code_i,
  input  logic              hold_i,
  input  logic              upd_i,
  output logic [CODE_W-1:0] pk_o,
  output logic              pk_vld_o
);
  logic [CODE_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      pk_o     <= '0;
      pk_vld_o <= 1'b0;
    end else begin
      pk_vld_o <= upd_i;
      if (upd_i) begin
        pk_o  <= run_q;
        run_q <= '0;
      end else if (smp_vld_i && !hold_i && (smp_code_i > run_q)) begin
        run_q <= smp_code_i;
      end
    end
  end
endmodule

// File: rtl/lbm_run_fsm.sv
module lbm_run_fsm
  import lbm_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int ON_CODE   = 228,
  parameter int OFF_CODE  = 204,
  parameter int DEB_NORM  = 75000,
  parameter int DEB_LIGHT = 235000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              light_i,
  input  logic              band_i,
  input  logic              pk_vld_i,
  input  logic [CODE_W-1:0] pk_i,
  output logic              en_o
);
  localparam int DMAX = (DEB_LIGHT > DEB_NORM) ? DEB_LIGHT : DEB_NORM;
  localparam int DW   = $clog2(DMAX + 1);

  bo_state_e     st_q;
  logic [DW-1:0] deb_q, deb_lim;
  logic          pk_ok, pk_hi;

  assign deb_lim = light_i ? DW'(DEB_LIGHT) : DW'(DEB_NORM);
  assign pk_hi   = pk_i >= CODE_W'(ON_CODE);
  assign pk_ok   = pk_i >= CODE_W'(OFF_CODE);
  assign en_o    = st_q != BO_OFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BO_OFF;
      deb_q <= '0;
    end else begin
      unique case (st_q)
        BO_OFF: begin
          deb_q <= '0;
          if (pk_vld_i && pk_hi && !band_i) st_q <= BO_RUN;
        end
        BO_RUN: begin
          deb_q <= '0;
          if (pk_vld_i && !pk_ok) st_q <= BO_PEND;
        end
        BO_PEND: begin
          if (pk_vld_i && pk_ok) begin
            st_q  <= BO_RUN;
            deb_q <= '0;
          end else if (tick_i) begin
            if (deb_q >= deb_lim - DW'(1)) begin
              st_q  <= BO_OFF;
              deb_q <= '0;
            end else begin
              deb_q <= deb_q + DW'(1);
            end
          end
        end
        default: st_q <= BO_OFF;
      endcase
    end
  end
endmodule

// File: rtl/lbm_limit_map.sv
module lbm_limit_map #(
  parameter int CODE_W    = 10,
  parameter int LIM_W     = 8,
  parameter int LINE_LO   = 244,
  parameter int LINE_HI   = 732,
  parameter int LIM_AT_LO = 230,
  parameter int LIM_AT_HI = 195
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pk_vld_i,
  input  logic [CODE_W-1:0] pk_i,
  input  logic              half_i,
  output logic [LIM_W-1:0]  limit_o
);
  localparam int SPAN = LINE_HI - LINE_LO;
  localparam int DROP = LIM_AT_LO - LIM_AT_HI;
  localparam int PW   = CODE_W + LIM_W;

  logic [LIM_W-1:0] lim_raw, lim_q;

  generate
    if (SPAN > 0) begin : g_interp
      logic [PW-1:0] prod, quo;
      always_comb begin
        prod = PW'(pk_i - CODE_W'(LINE_LO)) * PW'(DROP);
        quo  = prod / PW'(SPAN);
        if (pk_i <= CODE_W'(LINE_LO))      lim_raw = LIM_W'(LIM_AT_LO);
        else if (pk_i >= CODE_W'(LINE_HI)) lim_raw = LIM_W'(LIM_AT_HI);
        else                               lim_raw = LIM_W'(PW'(LIM_AT_LO) - quo);
      end
    end else begin : g_step
      assign lim_raw = (pk_i >= CODE_W'(LINE_LO)) ? LIM_W'(LIM_AT_HI) : LIM_W'(LIM_AT_LO);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lim_q <= LIM_W'(LIM_AT_HI);
    else if (pk_vld_i) lim_q <= lim_raw;
  end

  assign limit_o = half_i ? (lim_q >> 1) : lim_q;
endmodule

// File: rtl/line_brownout_mon.sv
module line_brownout_mon #(
  parameter int CODE_W    = 10,
  parameter int LIM_W     = 8,
  parameter int CYC_NORM  = 220,
  parameter int CYC_LIGHT = 650,
  parameter int HOLD      = 20,
  parameter int DEB_NORM  = 75000,
  parameter int DEB_LIGHT = 235000,
  parameter int ON_CODE   = 228,
  parameter int OFF_CODE  = 204,
  parameter int LINE_LO   = 244,
  parameter int LINE_HI   = 732,
  parameter int LIM_AT_LO = 230,
  parameter int LIM_AT_HI = 195
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              smp_vld_i,
  input  logic [CODE_W-1:0] smp_code_i,
  input  logic              light_load_i,
  input  logic              half_lim_i,
  input  logic              vdd_band_i,
  output logic              pwm_en_o,
  output logic [LIM_W-1:0]  limit_o
);
  // HOLD >= 1 keeps the update tick outside the sampling window
  logic              upd, hold, pk_vld;
  logic [CODE_W-1:0] pk_q;

  lbm_cycle_timer #(
    .CYC_NORM(CYC_NORM), .CYC_LIGHT(CYC_LIGHT), .HOLD(HOLD)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .light_i(light_load_i),
    .upd_o(upd), .hold_o(hold)
  );

  lbm_peak_hold #(.CODE_W(CODE_W)) u_peak (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i), .smp_code_i(smp_code_i),
    .hold_i(hold), .upd_i(upd), .pk_o(pk_q), .pk_vld_o(pk_vld)
  );

  lbm_run_fsm #(
    .CODE_W(CODE_W), .ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE),
    .DEB_NORM(DEB_NORM), .DEB_LIGHT(DEB_LIGHT)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .light_i(light_load_i),
    .band_i(vdd_band_i), .pk_vld_i(pk_vld), .pk_i(pk_q), .en_o(pwm_en_o)
  );

  lbm_limit_map #(
    .CODE_W(CODE_W), .LIM_W(LIM_W), .LINE_LO(LINE_LO), .LINE_HI(LINE_HI),
    .LIM_AT_LO(LIM_AT_LO), .LIM_AT_HI(LIM_AT_HI)
  ) u_limit (
    .clk_i(clk_i), .rst_ni(rst_ni), .pk_vld_i(pk_vld), .pk_i(pk_q),
    .half_i(half_lim_i), .limit_o(limit_o)
  );
endmodule

// File: rtl/line_brownout_mon_chk.sv
module line_brownout_mon_chk #(
  parameter int CODE_W    = 10,
  parameter int LIM_W     = 8,
  parameter int ON_CODE   = 228,
  parameter int OFF_CODE  = 204,
  parameter int LIM_AT_LO = 230,
  parameter int LIM_AT_HI = 195
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_i,
  input logic              pk_vld_i,
  input logic [CODE_W-1:0] pk_i,
  input logic              vdd_band_i,
  input logic              half_lim_i,
  input logic              pwm_en_o,
  input logic [LIM_W-1:0]  limit_o
);
  // R4
  start_needs_peak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_en_o) |-> ($past(pk_vld_i) && ($past(pk_i) >= CODE_W'(ON_CODE))));

  // R5
  start_blocked_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_en_o) |-> !$past(vdd_band_i));

  // R9
  no_stop_on_good_peak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_en_o) |-> !($past(pk_vld_i) && ($past(pk_i) >= CODE_W'(OFF_CODE))));

  // R2
  peak_moves_on_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pk_i) |-> $past(upd_i));

  // R10
  limit_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(pk_vld_i) && $stable(half_lim_i)) |-> $stable(limit_o));

  // R10
  limit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_lim_i |-> ((limit_o >= LIM_W'(LIM_AT_HI)) && (limit_o <= LIM_W'(LIM_AT_LO))));

  // R11
  limit_half_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_lim_i |-> (limit_o <= LIM_W'(LIM_AT_LO / 2)));
endmodule

bind line_brownout_mon line_brownout_mon_chk #(
  .CODE_W(CODE_W), .LIM_W(LIM_W), .ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE),
  .LIM_AT_LO(LIM_AT_LO), .LIM_AT_HI(LIM_AT_HI)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd), .pk_vld_i(pk_vld), .pk_i(pk_q),
  .vdd_band_i(vdd_band_i), .half_lim_i(half_lim_i), .pwm_en_o(pwm_en_o),
  .limit_o(limit_o)
);

// File: tb/line_brownout_mon_tb_top.sv
module line_brownout_mon_tb_top;
  localparam int LN = 8, LL = 20, HOLD = 2, DN = 40, DL = 100;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic       smp_vld = 1'b0, light = 1'b0, half = 1'b0, band = 1'b0;
  logic [9:0] smp_code = '0;
  logic       pwm_en;
  logic [7:0] limit;
  int         n_run = 0, n_fail = 0, ph = 0;

  always #10 clk = ~clk;

  line_brownout_mon #(
    .CYC_NORM(LN), .CYC_LIGHT(LL), .HOLD(HOLD), .DEB_NORM(DN), .DEB_LIGHT(DL)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .smp_vld_i(smp_vld),
    .smp_code_i(smp_code), .light_load_i(light), .half_lim_i(half),
    .vdd_band_i(band), .pwm_en_o(pwm_en), .limit_o(limit)
  );

  // cycle phase from R1: ticks since cycle start
  always @(posedge clk) begin
    if (!rst_n) ph <= 0;
    else if (tick) ph <= (ph >= (light ? LL : LN) - 1) ? 0 : ph + 1;
  end

  function automatic int exp_lim(int pk);
    if (pk <= 244) return 230;
    if (pk >= 732) return 195;
    return 230 - ((pk - 244) * 35) / 488;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic align();
    @(negedge clk);
    while (ph != 0) @(negedge clk);
  endtask

  // one full cycle of base samples with a single peak at position pos
  task automatic run_cycle(int base, int peak, int pos);
    int len = light ? LL : LN;
    align();
    for (int i = 0; i < len; i++) begin
      smp_vld  = 1'b1;
      smp_code = 10'((i == pos) ? peak : base);
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 en", int'(pwm_en), 0);
    chk("R12 limit", int'(limit), 195);
    rst_n = 1'b1;

    run_cycle(100, 100, 0);
    chk("R10 low sat", int'(limit), 230);
    chk("R9 below off", int'(pwm_en), 0);
    run_cycle(210, 220, 3);
    chk("R9 band stays off", int'(pwm_en), 0);

    band = 1'b1;
    run_cycle(300, 300, 0);
    chk("R5 blocked", int'(pwm_en), 0);
    band = 1'b0;
    run_cycle(300, 300, 0);
    chk("R4 start", int'(pwm_en), 1);
    chk("R10 mid", int'(limit), exp_lim(300));

    run_cycle(250, 600, 3);
    chk("R2 peak", int'(limit), exp_lim(600));
    run_cycle(250, 250, 0);
    chk("R2 cleared", int'(limit), exp_lim(250));
    run_cycle(250, 900, LN - 1);
    chk("R3 last tick", int'(limit), exp_lim(250));
    run_cycle(250, 900, LN - HOLD);
    chk("R3 first hold tick", int'(limit), exp_lim(250));
    run_cycle(250, 500, LN - HOLD - 1);
    chk("R3 last open tick", int'(limit), exp_lim(500));

    run_cycle(210, 210, 0);
    chk("R9 stays on", int'(pwm_en), 1);
    half = 1'b1;
    @(negedge clk);
    chk("R11 half", int'(limit), exp_lim(210) / 2);
    half = 1'b0;
    @(negedge clk);
    chk("R11 full", int'(limit), exp_lim(210));

    // R8: low then recovery before expiry
    align();
    smp_code = 10'd150;
    repeat (2 * LN) @(negedge clk);
    smp_code = 10'd300;
    repeat (LN + 1) @(negedge clk);
    chk("R8 cancelled", int'(pwm_en), 1);
    align();
    smp_code = 10'd150;
    repeat (LN + DN) @(negedge clk);
    chk("R6 before expiry", int'(pwm_en), 1);
    @(negedge clk);
    chk("R6 expiry", int'(pwm_en), 0);

    run_cycle(300, 300, 0);
    chk("R4 restart", int'(pwm_en), 1);

    light = 1'b1;
    run_cycle(300, 700, 12);
    chk("R1 light cycle", int'(limit), exp_lim(700));
    align();
    smp_code = 10'd150;
    repeat (LL + DL) @(negedge clk);
    chk("R7 before expiry", int'(pwm_en), 1);
    @(negedge clk);
    chk("R7 expiry", int'(pwm_en), 0);
    light = 1'b0;

    for (int c = 0; c < 1024; c++) begin
      smp_code = 10'(c);
      repeat (2 * LN + 2) @(negedge clk);
      chk("R10 sweep", int'(limit), exp_lim(c));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule